// File: doc/BRIEF.md
# Base-Limit Address Relocation Guard

This block sits between a processor's storage address register and a shared word-addressed memory. Several jobs are stored one after another in that memory. Each job gives logical addresses that start at zero. The guard adds the running job's base to every logical address. It lets the access through only when the resulting physical address is below the job's limit, where the limit is the job's base plus its program length.

An access that leaves the job's window never reaches memory. A write out of range is blocked, and a read out of range is blocked as well. The access instead raises a registered fault that carries the offending logical address and whether the access was a write. The scheduler uses this fault to abort only that job. The fault stays set, and every further access stays blocked, until the scheduler acknowledges it.

The scheduler installs a job's base and limit with a context-restore strobe. The guard refuses a restore in three cases, and keeps the old window in each:
- it arrives while an access strobe is active;
- its limit reaches the end of physical memory;
- its base lies above its limit.

Top module: `relocGuard`

## Requirements
- R1: During a granted access, `memAddr` equals the installed base plus `logAddr`, and `memWdata` equals `wrData`, in the same cycle as the strobe.
- R2: An access is granted (`memEn` high in the same cycle) only when base plus `logAddr` is strictly below the installed limit. `memWe` is high only for a granted access with `wrReq` high. The highest legal logical address is limit minus base minus 1.
- R3: An access at or beyond the limit leaves `memEn` and `memWe` low in that cycle, so memory is not written.
- R4: After an out-of-range access, `fault` is high from the next clock edge. `faultAddr` then holds that access's logical address, and `faultIsWrite` is 1 for a write and 0 for a read.
- R5: While `fault` is high, `memEn` and `memWe` stay low for every access. `fault` stays high, and `faultAddr` and `faultIsWrite` keep the first offender, until acknowledged.
- R6: `faultAck` high while `fault` is high clears `fault` at the next edge.
- R7: `ctxLoad` with no access strobe and legal values installs `ctxBase` and `ctxLimit`. Accesses from the next cycle onward use the new values.
- R8: `ctxLoad` in a cycle where `rdReq` or `wrReq` is high is ignored, and the old base and limit stay in force. `ctxReject` is high for exactly the following cycle.
- R9: `ctxLoad` with `ctxLimit` of 512 or more, or with `ctxBase` greater than `ctxLimit`, is ignored with the old window kept. `ctxReject` is high for exactly the following cycle.
- R10: After reset, base and limit are 0, and `fault`, `faultAddr`, `faultIsWrite` and `ctxReject` are 0. Any access before the first restore therefore faults.
- R11: The base-plus-address sum is formed without wrap-around. A logical address near 0xFFFF with a high base faults rather than landing low in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ctxLoad | input | 1 | Context-restore strobe from the scheduler |
| ctxBase | input | 9 | Base (load address) of the job being restored |
| ctxLimit | input | 10 | Limit (base plus length) of the job being restored |
| faultAck | input | 1 | Scheduler acknowledge that clears the fault |
| rdReq | input | 1 | Read strobe from the processor |
| wrReq | input | 1 | Write strobe from the processor |
| logAddr | input | 16 | Logical word address |
| wrData | input | 32 | Write data |
| memAddr | output | 9 | Physical word address to memory |
| memEn | output | 1 | Gated memory enable |
| memWe | output | 1 | Gated memory write enable |
| memWdata | output | 32 | Write data to memory |
| fault | output | 1 | Registered, sticky bounds fault |
| faultAddr | output | 16 | Logical address of the faulting access |
| faultIsWrite | output | 1 | Faulting access was a write |
| ctxReject | output | 1 | One-cycle pulse after a refused context restore |

## Verification
The bench builds the guard with its default parameters: a 16-bit logical address, 512 physical words and 32-bit data. With these values a window can be placed at the very top of memory (base 500, limit 511), and a restore with limit exactly 512 can be offered and refused. A logical address of 0xFFFF can be sent with that high base, and this exercises the no-wrap sum. The bench also tests both edges of a mid-memory window, restores that collide with an access, and a series of accesses that are blocked while a fault is pending.

// File: rtl/relocPkg.sv
package relocPkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic loadCtx;       // install ctxBase / ctxLimit this edge
    logic captureFault;  // latch logical address and access kind
  } relocStrobesT;

endpackage

// File: rtl/relocDatapath.sv
module relocDatapath
  import relocPkg::*;
#(
  parameter int LOG_AW     = 16,
  parameter int PHYS_WORDS = 512,
  parameter int DATA_W     = 32,
  localparam int PHYS_AW   = $clog2(PHYS_WORDS),
  localparam int LIMIT_W   = PHYS_AW + 1,
  localparam int SUM_W     = ((LOG_AW > LIMIT_W) ? LOG_AW : LIMIT_W) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  relocStrobesT       strobes,
  input  logic [PHYS_AW-1:0] ctxBase,
  input  logic [LIMIT_W-1:0] ctxLimit,
  input  logic [LOG_AW-1:0]  logAddr,
  input  logic               wrReq,
  input  logic [DATA_W-1:0]  wrData,
  output logic               inBounds,
  output logic               ctxOk,
  output logic [PHYS_AW-1:0] memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic [LOG_AW-1:0]  faultAddr,
  output logic               faultIsWrite
);

  localparam logic [LIMIT_W-1:0] TOP_LIMIT = LIMIT_W'(PHYS_WORDS);

  logic [PHYS_AW-1:0] baseQ;
  logic [LIMIT_W-1:0] limitQ;
  logic [SUM_W-1:0]   physSum;

  // Window registers: written only when control grants a restore.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else if (strobes.loadCtx) begin
      baseQ  <= ctxBase;
      limitQ <= ctxLimit;
    end
  end

  // Fault record: written only on the first offending access.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultAddr    <= '0;
      faultIsWrite <= 1'b0;
    end else if (strobes.captureFault) begin
      faultAddr    <= logAddr;
      faultIsWrite <= wrReq;
    end
  end

  // Relocation adder, one bit wider than either operand so it cannot wrap.
  always_comb begin
    physSum  = SUM_W'(baseQ) + SUM_W'(logAddr);
    inBounds = physSum < SUM_W'(limitQ);
    memAddr  = physSum[PHYS_AW-1:0];
    memWdata = wrData;
  end

  // A window must end before the top of memory and must not be inverted.
  always_comb begin
    ctxOk = (ctxLimit < TOP_LIMIT) && (LIMIT_W'(ctxBase) <= ctxLimit);
  end

endmodule

// File: rtl/relocControl.sv
module relocControl
  import relocPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdReq,
  input  logic         wrReq,
  input  logic         ctxLoad,
  input  logic         faultAck,
  input  logic         inBounds,
  input  logic         ctxOk,
  output relocStrobesT strobes,
  output logic         memEn,
  output logic         memWe,
  output logic         fault,
  output logic         ctxReject
);

  logic accessing;
  logic violation;
  logic refuse;

  always_comb begin
    accessing = rdReq | wrReq;
    memEn     = accessing & inBounds & ~fault;
    memWe     = wrReq & inBounds & ~fault;
    violation = accessing & ~inBounds & ~fault;
    refuse    = ctxLoad & (accessing | ~ctxOk);

    strobes.loadCtx      = ctxLoad & ~accessing & ctxOk;
    strobes.captureFault = violation;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fault     <= 1'b0;
      ctxReject <= 1'b0;
    end else begin
      ctxReject <= refuse;
      if (violation)     fault <= 1'b1;
      else if (faultAck) fault <= 1'b0;
    end
  end

endmodule

// File: rtl/relocGuard.sv
module relocGuard
  import relocPkg::*;
#(
  parameter int LOG_AW     = 16,
  parameter int PHYS_WORDS = 512,
  parameter int DATA_W     = 32,
  localparam int PHYS_AW   = $clog2(PHYS_WORDS),
  localparam int LIMIT_W   = PHYS_AW + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctxLoad,
  input  logic [PHYS_AW-1:0] ctxBase,
  input  logic [LIMIT_W-1:0] ctxLimit,
  input  logic               faultAck,
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic [LOG_AW-1:0]  logAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [PHYS_AW-1:0] memAddr,
  output logic               memEn,
  output logic               memWe,
  output logic [DATA_W-1:0]  memWdata,
  output logic               fault,
  output logic [LOG_AW-1:0]  faultAddr,
  output logic               faultIsWrite,
  output logic               ctxReject
);

  relocStrobesT strobes;
  logic         inBounds;
  logic         ctxOk;

  relocControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .rdReq     (rdReq),
    .wrReq     (wrReq),
    .ctxLoad   (ctxLoad),
    .faultAck  (faultAck),
    .inBounds  (inBounds),
    .ctxOk     (ctxOk),
    .strobes   (strobes),
    .memEn     (memEn),
    .memWe     (memWe),
    .fault     (fault),
    .ctxReject (ctxReject)
  );

  relocDatapath #(
    .LOG_AW     (LOG_AW),
    .PHYS_WORDS (PHYS_WORDS),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .ctxBase      (ctxBase),
    .ctxLimit     (ctxLimit),
    .logAddr      (logAddr),
    .wrReq        (wrReq),
    .wrData       (wrData),
    .inBounds     (inBounds),
    .ctxOk        (ctxOk),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .faultAddr    (faultAddr),
    .faultIsWrite (faultIsWrite)
  );

endmodule

// File: rtl/relocGuardChecker.sv
module relocGuardChecker #(
  parameter int LOG_AW  = 16,
  parameter int PHYS_AW = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               ctxLoad,
  input logic               faultAck,
  input logic               rdReq,
  input logic               wrReq,
  input logic [LOG_AW-1:0]  logAddr,
  input logic [PHYS_AW-1:0] memAddr,
  input logic               memEn,
  input logic               memWe,
  input logic               fault,
  input logic [LOG_AW-1:0]  faultAddr,
  input logic               faultIsWrite,
  input logic               ctxReject
);

  // Write enable only accompanies a granted write.
  assert_we_granted_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memEn && wrReq));

  // A refused access raises the fault and records the offender next cycle.
  assert_fault_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((rdReq || wrReq) && !memEn && !fault) |=>
      (fault && faultAddr == $past(logAddr) && faultIsWrite == $past(wrReq)));

  // Nothing reaches memory while a fault is pending.
  assert_blocked_in_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!memEn && !memWe));

  // Pending fault and its record hold until acknowledged.
  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !faultAck) |=> (fault && $stable(faultAddr) && $stable(faultIsWrite)));

  // Acknowledge clears the fault.
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fault && faultAck) |=> !fault);

  // Window unchanged with no restore: same logical address maps the same way.
  assert_stable_map_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn) && !$past(ctxLoad) && $stable(logAddr)) |-> $stable(memAddr));

  // A restore that collides with an access is refused.
  assert_ctx_collide_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctxLoad && (rdReq || wrReq)) |=> ctxReject);

  // Without a restore attempt there is no refusal pulse.
  assert_reject_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctxLoad |=> !ctxReject);

endmodule

bind relocGuard relocGuardChecker #(
  .LOG_AW  (LOG_AW),
  .PHYS_AW (PHYS_AW)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ctxLoad      (ctxLoad),
  .faultAck     (faultAck),
  .rdReq        (rdReq),
  .wrReq        (wrReq),
  .logAddr      (logAddr),
  .memAddr      (memAddr),
  .memEn        (memEn),
  .memWe        (memWe),
  .fault        (fault),
  .faultAddr    (faultAddr),
  .faultIsWrite (faultIsWrite),
  .ctxReject    (ctxReject)
);

// File: tb/relocGuard_bench.sv
module relocGuard_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctxLoad = 1'b0;
  logic [8:0]  ctxBase = '0;
  logic [9:0]  ctxLimit = '0;
  logic        faultAck = 1'b0;
  logic        rdReq = 1'b0;
  logic        wrReq = 1'b0;
  logic [15:0] logAddr = '0;
  logic [31:0] wrData = '0;
  logic [8:0]  memAddr;
  logic        memEn;
  logic        memWe;
  logic [31:0] memWdata;
  logic        fault;
  logic [15:0] faultAddr;
  logic        faultIsWrite;
  logic        ctxReject;

  always #(CLK_PERIOD/2) clk = ~clk;

  relocGuard u_relocGuard (
    .clk          (clk),
    .rstN         (rstN),
    .ctxLoad      (ctxLoad),
    .ctxBase      (ctxBase),
    .ctxLimit     (ctxLimit),
    .faultAck     (faultAck),
    .rdReq        (rdReq),
    .wrReq        (wrReq),
    .logAddr      (logAddr),
    .wrData       (wrData),
    .memAddr      (memAddr),
    .memEn        (memEn),
    .memWe        (memWe),
    .memWdata     (memWdata),
    .fault        (fault),
    .faultAddr    (faultAddr),
    .faultIsWrite (faultIsWrite),
    .ctxReject    (ctxReject)
  );

  typedef struct {
    logic        en;
    logic        we;
    logic [8:0]  addr;
    logic [31:0] data;
    logic        flt;
    logic        fw;
    logic [15:0] fa;
    logic        rej;
    string       tag;
  } expT;

  expT expQ[$];
  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // Reference state, derived from the requirements.
  logic [8:0]  mBase = '0;
  logic [9:0]  mLimit = '0;
  logic        mFault = 1'b0;
  logic [15:0] mFaultAddr = '0;
  logic        mFaultWr = 1'b0;
  logic        mReject = 1'b0;

  // Driver: apply one cycle of stimulus and queue the expected outputs.
  task automatic step(input logic rd, input logic wr, input logic [15:0] a,
                      input logic [31:0] d, input logic cl, input logic [8:0] cb,
                      input logic [9:0] clim, input logic ack, input string tag);
    expT         e;
    logic [16:0] phys;
    logic        inb, acc, viol, ok;
    @(negedge clk);
    rdReq = rd; wrReq = wr; logAddr = a; wrData = d;
    ctxLoad = cl; ctxBase = cb; ctxLimit = clim; faultAck = ack;
    phys = 17'(mBase) + 17'(a);
    inb  = phys < 17'(mLimit);
    acc  = rd | wr;
    e.en = acc & inb & ~mFault;
    e.we = wr & e.en;
    e.addr = phys[8:0];
    e.data = d;
    e.flt = mFault; e.fw = mFaultWr; e.fa = mFaultAddr; e.rej = mReject;
    e.tag = tag;
    expQ.push_back(e);
    viol = acc & ~inb & ~mFault;
    if (viol) begin
      mFault = 1'b1; mFaultAddr = a; mFaultWr = wr;
    end else if (ack) begin
      mFault = 1'b0;
    end
    ok = (clim < 10'd512) && ({1'b0, cb} <= clim);
    mReject = cl & (acc | ~ok);
    if (cl & ~acc & ok) begin
      mBase = cb; mLimit = clim;
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 9'h0, 10'h0, 1'b0, tag);
  endtask

  task automatic restore(input logic [8:0] cb, input logic [9:0] clim, input string tag);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b1, cb, clim, 1'b0, tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, 1'b0, 9'h0, 10'h0, 1'b0, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    step(1'b0, 1'b1, a, d, 1'b0, 9'h0, 10'h0, 1'b0, tag);
  endtask

  task automatic ack(input string tag);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 9'h0, 10'h0, 1'b1, tag);
  endtask

  // Monitor: compare the design's outputs with the queued expectations.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expT e;
        bit  good;
        e = expQ.pop_front();
        checks++;
        good = (memEn === e.en) && (memWe === e.we) && (fault === e.flt) &&
               (faultAddr === e.fa) && (faultIsWrite === e.fw) &&
               (ctxReject === e.rej) &&
               (!e.en || (memAddr === e.addr && memWdata === e.data));
        if (!good) begin
          fails++;
          $display("FAIL %s: got en=%b we=%b addr=%0d data=%h flt=%b fa=%h fw=%b rej=%b, expected en=%b we=%b addr=%0d data=%h flt=%b fa=%h fw=%b rej=%b",
                   e.tag, memEn, memWe, memAddr, memWdata, fault, faultAddr, faultIsWrite, ctxReject,
                   e.en, e.we, e.addr, e.data, e.flt, e.fa, e.fw, e.rej);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    idle("R10 reset state");
    rd(16'd0, "R10 access before restore refused");
    idle("R4 read fault raised");
    ack("R6 ack issued");
    idle("R6 fault cleared");

    restore(9'd100, 10'd150, "R7 restore window 100..149");
    rd(16'd10, "R1 read relocated to 110");
    wr(16'd49, 32'hCAFE_0049, "R2 write at top legal word 149");
    wr(16'd50, 32'hDEAD_0050, "R3 write at limit blocked");
    rd(16'd5, "R5 read blocked while faulted");
    wr(16'd7, 32'h1234_5678, "R5 write blocked, first offender kept");
    ack("R6 ack of write fault");
    idle("R6 fault cleared after write fault");

    step(1'b1, 1'b0, 16'd20, 32'h0, 1'b1, 9'd0, 10'd10, 1'b0, "R8 restore during read refused");
    rd(16'd20, "R8 old window still in force");
    restore(9'd500, 10'd512, "R9 restore with limit 512");
    restore(9'd300, 10'd200, "R9 restore with inverted window");
    rd(16'd20, "R9 old window kept after refusals");

    restore(9'd500, 10'd511, "R7 restore window 500..510");
    wr(16'd10, 32'h0000_0510, "R2 write at word 510");
    rd(16'd11, "R3 read at limit 511 refused");
    ack("R4 read fault recorded");
    rd(16'hFFFF, "R11 no wrap for 500 + 0xFFFF");
    idle("R11 fault with address FFFF");
    ack("R6 final ack");
    idle("R6 final clear");
    rd(16'd0, "R1 read at base 500");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule